// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Transmit Appender

This block sits in a minimal MAC transmit path between a byte-wide payload source and the byte stream that heads towards the PHY. Each payload byte it accepts is copied to the output one cycle later, unchanged. As the byte goes past, a 32-bit CRC register is advanced by one full byte in a single cycle. The CRC arithmetic works most-significant bit first, so each payload byte has its bit order reversed before it reaches the CRC step.

When the byte marked last has been accepted, the block emits four frame check sequence bytes back to back. These bytes come from the final register value, inverted and then bit-reversed as a whole 32-bit word. While the four bytes go out, the source is held off through a ready signal, so a new frame cannot start until the check sequence has left.

Preamble, start delimiter, padding, inter-frame gap and PHY signalling are handled elsewhere.

The controller has three states:
- IDLE: waits for a start of frame.
- PAYLOAD: passes bytes and updates the CRC.
- FCS: emits the check bytes with ready held low.

The transitions between them are:
- SOF_SEEN: IDLE to PAYLOAD, on an accepted byte flagged as a frame start.
- SINGLE_BYTE: IDLE to FCS, on an accepted byte flagged as both start and last.
- TAIL_REACHED: PAYLOAD to FCS, on an accepted byte flagged as last.
- FCS_DONE: FCS to IDLE, when the fourth check byte is emitted.

Top module: `fcs_tx_append`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` and `out_last` are low and `in_ready` is high; a reset in mid-frame abandons that frame.
- R2: The CRC register is preset to 0xFFFFFFFF by the first byte of every frame, so the check sequence of a frame does not depend on earlier frames.
- R3: A payload byte accepted on a clock edge (`in_valid` and `in_ready` both high) appears unchanged on `out_data`, with `out_valid` high and `out_last` low, in the cycle after that edge.
- R4: Each accepted byte is bit-reversed (bit 0 becomes bit 7) and then shifted into the CRC most significant bit first, using the polynomial 0x04C11DB7.
- R5: The check word is the bitwise inverse of the final CRC register with all 32 bits reversed. It is emitted as four bytes, bits 31..24 first, in the four cycles immediately after the last payload byte. For payload 00 00 12 33 FF FF the bytes are D3 D9 77 81.
- R6: `out_last` is high only with the fourth check byte, and never with a payload byte.
- R7: `in_ready` is low for exactly four cycles after the last payload byte is accepted. A frame start presented during that time is taken on the first edge after the fourth check byte, so a second frame follows with no idle output cycle.
- R8: In IDLE, valid bytes without `in_sof` are discarded: nothing is output and the CRC is not touched.
- R9: A byte with both `in_sof` and `in_last` set forms a one-byte frame, followed by its four check bytes.
- R10: Cycles with `in_valid` low inside a frame produce no output and leave the CRC unchanged.
- R11: `in_sof` on a byte in the middle of a frame is ignored; that byte is handled as ordinary payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte from the source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last payload byte of a frame |
| in_ready | output | 1 | Block takes a byte on this edge if valid |
| out_data | output | 8 | Byte towards the PHY side |
| out_valid | output | 1 | `out_data` holds a byte |
| out_last | output | 1 | Byte is the final check byte of a frame |

## Verification
The hardest situation to reach is a new frame start that is already waiting while check bytes are still pending. It must be held through all four ready-low cycles and then taken with no bubble, and the fresh CRC preset must not pick up the old register. The bench reaches it by issuing the next frame's first byte in the same time step in which the previous frame's last byte is accepted. It then checks the ready-low count, both frames' check sequences, and that the output span has no gap. Further directed runs present sourceless bytes in IDLE, a mid-frame start flag, idle gaps inside a frame, and a reset while a frame is in flight.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_FCS     = 2'd2
    } fcs_state_t;

    localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;

endpackage

// File: rtl/fcs_bit_reverse.sv
module fcs_bit_reverse #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign dout[g] = din[W-1-g];
    end

endmodule

// File: rtl/fcs_crc_core.sv
module fcs_crc_core #(
    parameter int          DW   = 8,
    parameter int          CW   = 32,
    parameter logic [CW-1:0] POLY = fcs_pkg::CRC32_POLY,
    parameter logic [CW-1:0] INIT = fcs_pkg::CRC32_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          restart,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc
);

    logic [CW-1:0] base;
    logic [CW-1:0] stepped;

    // One full input word per cycle, most significant input bit first.
    function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c,
                                               input logic [DW-1:0] d);
        logic [CW-1:0] r;
        logic          fb;
        r = c;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = r[CW-1] ^ d[i];
            r  = {r[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return r;
    endfunction

    always_comb begin
        base    = restart ? INIT : crc;
        stepped = crc_step(base, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= INIT;
        end else if (upd) begin
            crc <= stepped;
        end
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(crc));

endmodule

// File: rtl/fcs_tx_ctrl.sv
module fcs_tx_ctrl #(
    parameter int FCS_BYTES = 4,
    localparam int IW = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_last,
    output logic          in_ready,
    output logic          accept,
    output logic          restart,
    output logic          fcs_emit,
    output logic          fcs_final,
    output logic [IW-1:0] fcs_idx
);
    import fcs_pkg::*;

    localparam logic [IW-1:0] IDX_LAST = IW'(FCS_BYTES - 1);

    fcs_state_t    state, state_nx;
    logic [IW-1:0] idx_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            fcs_idx <= '0;
        end else begin
            state   <= state_nx;
            fcs_idx <= idx_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        idx_nx    = fcs_idx;
        in_ready  = 1'b1;
        accept    = 1'b0;
        restart   = 1'b0;
        fcs_emit  = 1'b0;
        fcs_final = 1'b0;
        unique case (state)
            ST_IDLE: begin
                accept  = in_valid && in_sof;
                restart = accept;
                if (accept) begin
                    idx_nx = '0;
                    // SINGLE_BYTE or SOF_SEEN
                    state_nx = in_last ? ST_FCS : ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                accept = in_valid;
                if (accept && in_last) begin
                    idx_nx   = '0;
                    state_nx = ST_FCS;  // TAIL_REACHED
                end
            end
            ST_FCS: begin
                in_ready  = 1'b0;
                fcs_emit  = 1'b1;
                fcs_final = (fcs_idx == IDX_LAST);
                if (fcs_final) begin
                    idx_nx   = '0;
                    state_nx = ST_IDLE; // FCS_DONE
                end else begin
                    idx_nx = fcs_idx + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                idx_nx   = '0;
            end
        endcase
    end

    // R7
    ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid && in_last));

    // R8
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !in_sof) |=> (state == ST_IDLE));

endmodule

// File: rtl/fcs_tx_append.sv
module fcs_tx_append #(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last
);
    localparam int FCS_BYTES = CRC_W / DATA_W;
    localparam int IW        = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

    logic              accept;
    logic              restart;
    logic              fcs_emit;
    logic              fcs_final;
    logic [IW-1:0]     fcs_idx;
    logic [DATA_W-1:0] data_rev;
    logic [CRC_W-1:0]  crc;
    logic [CRC_W-1:0]  crc_inv;
    logic [CRC_W-1:0]  fcs_word;
    logic [DATA_W-1:0] fcs_byte;

    fcs_tx_ctrl #(.FCS_BYTES(FCS_BYTES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .accept    (accept),
        .restart   (restart),
        .fcs_emit  (fcs_emit),
        .fcs_final (fcs_final),
        .fcs_idx   (fcs_idx)
    );

    fcs_bit_reverse #(.W(DATA_W)) rev_in_i (
        .din  (in_data),
        .dout (data_rev)
    );

    fcs_crc_core #(.DW(DATA_W), .CW(CRC_W)) crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (accept),
        .restart (restart),
        .din     (data_rev),
        .crc     (crc)
    );

    assign crc_inv = ~crc;

    fcs_bit_reverse #(.W(CRC_W)) rev_out_i (
        .din  (crc_inv),
        .dout (fcs_word)
    );

    // Most significant byte of the check word goes out first.
    always_comb begin
        fcs_byte = '0;
        for (int b = 0; b < FCS_BYTES; b++) begin
            if (fcs_idx == IW'(b)) begin
                fcs_byte = fcs_word[CRC_W-1-b*DATA_W -: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_last  <= 1'b0;
            out_data  <= in_data;
        end else if (fcs_emit) begin
            out_valid <= 1'b1;
            out_last  <= fcs_final;
            out_data  <= fcs_byte;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && accept) |=> (out_valid && !out_last && out_data == $past(in_data)));

    // R6
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R7
    ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> in_ready);

endmodule

// File: tb/fcs_tx_append_tb.sv
`timescale 1ns/1ps
module fcs_tx_append_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;

    always #2 clk = ~clk;

    fcs_tx_append dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sof(in_sof), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int ncap  = 0;
    int nlow  = 0;
    logic [7:0] cap      [0:255];
    logic       cap_last [0:255];
    int         cap_cyc  [0:255];

    // vector table: length, seed, idle gap every N bytes (0 none), mid sof index (-1 none)
    localparam int NV = 6;
    localparam int VLEN [NV] = '{1, 2, 5, 17, 46, 64};
    localparam int VSEED[NV] = '{3, 9, 21, 40, 77, 5};
    localparam int VGAP [NV] = '{0, 0, 2, 0, 7, 0};
    localparam int VSOF [NV] = '{-1, -1, -1, 4, -1, 30};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired act=%0d exp<%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (out_valid) begin
            cap[ncap]      = out_data;
            cap_last[ncap] = out_last;
            cap_cyc[ncap]  = cyc;
            ncap           = ncap + 1;
        end
        if (!in_ready) nlow = nlow + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        if (seed < 0) begin
            case (i)
                0: return 8'h00;
                1: return 8'h00;
                2: return 8'h12;
                3: return 8'h33;
                default: return 8'hFF;
            endcase
        end
        return 8'((seed * 37 + i * 11 + ((i * i) >> 3)) & 255);
    endfunction

    // Model built from R2, R4, R5.
    function automatic logic [31:0] fcs_model(input int seed, input int len);
        logic [31:0] c;
        logic [31:0] w;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            b = gen(seed, i);
            for (int k = 0; k < 8; k++) begin
                fb = c[31] ^ b[k];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        c = ~c;
        for (int k = 0; k < 32; k++) w[k] = c[31-k];
        return w;
    endfunction

    task automatic send(input int seed, input int len, input int gap, input int sofmid);
        bit ok;
        for (int i = 0; i < len; i++) begin
            if (gap != 0 && i != 0 && (i % gap) == 0) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = gen(seed, i);
            in_sof   = (i == 0) || (i == sofmid);
            in_last  = (i == len - 1);
            do begin
                ok = in_ready;
                @(posedge clk); #1;
            end while (!ok);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic check_seg(input int base, input int seed, input int len, input string req);
        logic [31:0] f;
        logic [31:0] got;
        bit          pay_ok;
        bit          last_ok;
        f = fcs_model(seed, len);
        pay_ok = 1'b1;
        last_ok = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (cap[base+i] !== gen(seed, i)) pay_ok = 1'b0;
            if (cap_last[base+i] !== 1'b0) last_ok = 1'b0;
        end
        got = {cap[base+len], cap[base+len+1], cap[base+len+2], cap[base+len+3]};
        for (int k = 0; k < 3; k++) if (cap_last[base+len+k] !== 1'b0) last_ok = 1'b0;
        if (cap_last[base+len+3] !== 1'b1) last_ok = 1'b0;
        chk(pay_ok, {req, " R3 payload bytes"}, 32'(len), 32'(len));
        chk(got == f, {req, " R4 R5 check word"}, got, f);
        chk(last_ok, {req, " R6 last flag"}, {31'd0, cap_last[base+len+3]}, 32'd1);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        // R1 reset state
        idle(3);
        chk(out_valid == 1'b0 && out_last == 1'b0, "R1 outputs in reset", {30'd0, out_valid, out_last}, 32'd0);
        chk(in_ready == 1'b1, "R1 ready in reset", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        idle(2);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", {30'd0, out_valid, in_ready}, 32'd1);

        // R5 known frame
        ncap = 0;
        send(-1, 6, 0, -1);
        idle(8);
        chk(ncap == 10, "R5 known frame length", 32'(ncap), 32'd10);
        chk({cap[6], cap[7], cap[8], cap[9]} == 32'hD3D9_7781, "R5 known check bytes",
            {cap[6], cap[7], cap[8], cap[9]}, 32'hD3D9_7781);
        check_seg(0, -1, 6, "R5 known");

        // vector table (R2 preset each frame, R9 one-byte, R10 gaps, R11 mid sof)
        for (int v = 0; v < NV; v++) begin
            ncap = 0;
            send(VSEED[v], VLEN[v], VGAP[v], VSOF[v]);
            idle(8);
            chk(ncap == VLEN[v] + 4, "R2 R9 R10 R11 output count", 32'(ncap), 32'(VLEN[v] + 4));
            check_seg(0, VSEED[v], VLEN[v], "R2 R9 R10 R11 vector");
        end

        // R8 bytes without sof in IDLE are dropped
        ncap = 0;
        in_valid = 1'b1; in_data = 8'hA5; in_sof = 1'b0; in_last = 1'b0;
        idle(3);
        in_last = 1'b1;
        idle(1);
        in_valid = 1'b0; in_last = 1'b0;
        idle(3);
        chk(ncap == 0, "R8 no output for sourceless bytes", 32'(ncap), 32'd0);
        send(12, 7, 0, -1);
        idle(8);
        check_seg(0, 12, 7, "R8 following frame");

        // R7 back-to-back frames with start held during check bytes
        ncap = 0;
        nlow = 0;
        send(50, 3, 0, -1);
        send(60, 2, 0, -1);
        idle(8);
        chk(nlow == 8, "R7 ready low cycles", 32'(nlow), 32'd8);
        chk(ncap == 13, "R7 total bytes", 32'(ncap), 32'd13);
        chk(cap_cyc[12] - cap_cyc[0] == 12, "R7 no output gap", 32'(cap_cyc[12] - cap_cyc[0]), 32'd12);
        check_seg(0, 50, 3, "R7 first");
        check_seg(7, 60, 2, "R7 second");

        // R1 reset in mid-frame
        ncap = 0;
        in_valid = 1'b1; in_sof = 1'b1; in_last = 1'b0; in_data = 8'h11;
        idle(1);
        in_sof = 1'b0; in_data = 8'h22;
        idle(1);
        in_valid = 1'b0;
        rst_n = 1'b0;
        idle(2);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-frame reset", {30'd0, out_valid, in_ready}, 32'd1);
        rst_n = 1'b1;
        idle(2);
        ncap = 0;
        send(33, 9, 0, -1);
        idle(8);
        chk(ncap == 13, "R1 R2 frame after reset count", 32'(ncap), 32'd13);
        check_seg(0, 33, 9, "R1 R2 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule